// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This unit watches a processor's bus and program counter and raises a debug trigger when a programmed combination of conditions matches. There are three comparators: an inclusive address window, a data compare with a don't-care mask, and a program-counter compare with its own mask. Each of two trigger levels picks any subset of these comparators and joins them with AND or OR.

In single-level mode the first level-1 match fires. In dual-level mode a level-1 match arms the unit, and a later level-2 match fires it. A firing produces a one-cycle pulse on either the halt output or the debug-interrupt output, as the control register selects. After a firing the unit stays quiet until the control register is written again.

Two masters can write the registers: a debug serial channel and supervisor-mode software. Both share one combinational read port.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset both request outputs are low and every register reads back zero.
- R2: Either write port stores a value, which the read port then returns. Select codes: 0 address low bound, 1 address high bound, 2 data value, 3 data mask, 4 PC value, 5 PC mask, 6 control (10 bits, upper bits read zero). Select code 7 reads zero.
- R3: When both write ports are strobed in the same cycle, the serial port's write takes effect and the supervisor write is dropped entirely, whatever its select code.
- R4: The address condition holds when bus_valid is high and low bound <= bus_addr <= high bound, with both bounds included.
- R5: The data condition holds when bus_valid is high and every bit whose data-mask bit is 0 equals the data register. Mask bits set to 1 are don't-care.
- R6: The PC condition uses the same masked compare against the PC pair. It is evaluated every cycle, independent of bus_valid.
- R7: Control bits [2:0] enable address, data and PC for level 1, and bit 3 selects OR (1) or AND (0) for level 1. Bits [6:4] and bit 7 do the same for level 2. A level with no enables never matches.
- R8: In single-level mode (control bit 8 = 0), a level-1 match in cycle t produces a response pulse lasting exactly one cycle after the clock edge that ends cycle t.
- R9: In dual-level mode (bit 8 = 1), a level-1 match arms the unit. Level-2 matches count only from the following cycle onward, while the unit is armed, and a level-2 match then fires.
- R10: Control bit 9 selects the response: 0 pulses halt_req, 1 pulses dbg_irq_req. The two outputs are never high together.
- R11: After firing, no further response occurs until the control register is written. A control write clears the armed state, and no response fires from the cycle in which the control register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Qualifies bus_addr and bus_data |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data word |
| cpu_pc | input | 32 | Current program counter |
| ser_wr | input | 1 | Serial channel write strobe |
| ser_sel | input | 3 | Serial channel register select |
| ser_wdata | input | 32 | Serial channel write data |
| sw_wr | input | 1 | Supervisor write strobe |
| sw_sel | input | 3 | Supervisor register select |
| sw_wdata | input | 32 | Supervisor write data |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data |
| halt_req | output | 1 | Halt request pulse |
| dbg_irq_req | output | 1 | Debug interrupt request pulse |

## Verification
A spent flag that fails to set shows up on the very next matching cycle as a second pulse. An armed flag that fails to set or clear shows up as a missing level-2 response, or as an extra one, one cycle after the level-2 match. A comparator boundary error, such as an exclusive window or an inverted mask, appears at the outputs one clock after the stimulus cycle. Register storage and port arbitration faults are visible at once on the read port.

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
  parameter int W    = 32,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic [W-1:0]    bus_addr,
  input  logic [W-1:0]    bus_data,
  input  logic [W-1:0]    cpu_pc,
  input  logic            ser_wr,
  input  logic [SELW-1:0] ser_sel,
  input  logic [W-1:0]    ser_wdata,
  input  logic            sw_wr,
  input  logic [SELW-1:0] sw_sel,
  input  logic [W-1:0]    sw_wdata,
  input  logic [SELW-1:0] rd_sel,
  output logic [W-1:0]    rd_data,
  output logic            halt_req,
  output logic            dbg_irq_req
);
  localparam int CW = 10;

  logic [W-1:0]  lo_q, hi_q, dat_q, dmsk_q, pc_q, pcm_q;
  logic [CW-1:0] ctrl_q;
  logic          armed_q, spent_q;

  logic            wr_en;
  logic [SELW-1:0] wr_sel;
  logic [W-1:0]    wr_val;
  assign wr_en  = ser_wr | sw_wr;
  assign wr_sel = ser_wr ? ser_sel : sw_sel;
  assign wr_val = ser_wr ? ser_wdata : sw_wdata;

  logic ctrl_we;
  assign ctrl_we = wr_en && (wr_sel == SELW'(6));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; dat_q <= '0; dmsk_q <= '0;
      pc_q <= '0; pcm_q <= '0; ctrl_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SELW'(0): lo_q   <= wr_val;
        SELW'(1): hi_q   <= wr_val;
        SELW'(2): dat_q  <= wr_val;
        SELW'(3): dmsk_q <= wr_val;
        SELW'(4): pc_q   <= wr_val;
        SELW'(5): pcm_q  <= wr_val;
        SELW'(6): ctrl_q <= wr_val[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SELW'(0): rd_data = lo_q;
      SELW'(1): rd_data = hi_q;
      SELW'(2): rd_data = dat_q;
      SELW'(3): rd_data = dmsk_q;
      SELW'(4): rd_data = pc_q;
      SELW'(5): rd_data = pcm_q;
      SELW'(6): rd_data = W'(ctrl_q);
      default:  rd_data = '0;
    endcase
  end

  logic addr_hit, data_hit, pc_hit;
  logic [2:0] hits;
  assign addr_hit = bus_valid && (bus_addr >= lo_q) && (bus_addr <= hi_q);
  assign data_hit = bus_valid && (((bus_data ^ dat_q) & ~dmsk_q) == '0);
  assign pc_hit   = (((cpu_pc ^ pc_q) & ~pcm_q) == '0);
  assign hits     = {pc_hit, data_hit, addr_hit};

  function automatic logic level_hit(input logic [2:0] en, input logic use_or,
                                     input logic [2:0] h);
    if (en == 3'b000) return 1'b0;
    return use_or ? |(h & en) : ((h & en) == en);
  endfunction

  logic l1, l2, dual, fire, arm_set;
  assign l1      = level_hit(ctrl_q[2:0], ctrl_q[3], hits);
  assign l2      = level_hit(ctrl_q[6:4], ctrl_q[7], hits);
  assign dual    = ctrl_q[8];
  assign fire    = !ctrl_we && !spent_q && (dual ? (armed_q && l2) : l1);
  assign arm_set = !ctrl_we && !spent_q && dual && !armed_q && l1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      spent_q <= 1'b0;
      halt_req <= 1'b0;
      dbg_irq_req <= 1'b0;
    end else begin
      halt_req    <= fire & ~ctrl_q[9];
      dbg_irq_req <= fire &  ctrl_q[9];
      if (ctrl_we) begin
        armed_q <= 1'b0;
        spent_q <= 1'b0;
      end else if (fire) begin
        armed_q <= 1'b0;
        spent_q <= 1'b1;
      end else if (arm_set) begin
        armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       dbg_irq_req,
  input logic       ctrl_we,
  input logic       armed_q,
  input logic       spent_q,
  input logic [9:0] ctrl_q
);
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq_req)); // R10
  AST_HALT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !$past(ctrl_q[9])); // R10
  AST_IRQ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_req |-> $past(ctrl_q[9])); // R10
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq_req) |=> !(halt_req || dbg_irq_req)); // R8
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (!armed_q && !spent_q)); // R11
  AST_DUAL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_req || dbg_irq_req) && $past(ctrl_q[8])) |-> $past(armed_q)); // R9
endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dbg_irq_req(dbg_irq_req),
  .ctrl_we(ctrl_we), .armed_q(armed_q), .spent_q(spent_q), .ctrl_q(ctrl_q)
);

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0, cpu_pc = 32'hFFFF_FFF0;
  logic ser_wr = 0, sw_wr = 0;
  logic [2:0] ser_sel = 0, sw_sel = 0, rd_sel = 0;
  logic [31:0] ser_wdata = 0, sw_wdata = 0, rd_data;
  logic halt_req, dbg_irq_req;

  localparam logic [31:0] IDLE_PC = 32'hFFFF_FFF0;

  always #5 clk = ~clk;

  dbg_trig_unit u0 (.*);

  typedef struct { logic h; logic i; string tag; } item_t;
  item_t q[$];
  int vecs = 0, errs = 0;
  bit done = 0;

  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vecs++;
      if (halt_req !== it.h || dbg_irq_req !== it.i) begin
        errs++;
        $display("FAIL %s: halt/irq = %b%b expected %b%b", it.tag, halt_req, dbg_irq_req, it.h, it.i);
      end
    end
  end

  task automatic push(input logic h, input logic i, input string tag);
    item_t it;
    it.h = h; it.i = i; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                      input logic [31:0] pc, input logic h, input logic i, input string tag);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; cpu_pc = pc;
    push(h, i, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, IDLE_PC, 0, 0, "R11 idle");
  endtask

  task automatic wr(input bit ser, input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    if (ser) begin ser_wr = 1; ser_sel = sel; ser_wdata = v; end
    else begin sw_wr = 1; sw_sel = sel; sw_wdata = v; end
    push(0, 0, "R11 write cycle");
    @(posedge clk); #2;
    ser_wr = 0; sw_wr = 0;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_sel = sel; #1;
    vecs++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s: rd_data[%0d] = %h expected %h", tag, sel, rd_data, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vecs++;
    if (halt_req !== 0 || dbg_irq_req !== 0) begin
      errs++; $display("FAIL R1: outputs %b%b expected 00", halt_req, dbg_irq_req);
    end
    for (int s = 0; s < 8; s++) rd_chk(s[2:0], 0, "R1 reset read");
    rst_n = 1;

    wr(1, 0, 32'h0000_1000);
    wr(0, 1, 32'h0000_1FFF);
    wr(1, 2, 32'hA5A5_0000);
    wr(0, 3, 32'h0000_FFFF);
    wr(1, 4, 32'h1000_0000);
    wr(0, 5, 32'h0000_00FF);
    wr(0, 7, 32'h1234_5678);
    rd_chk(0, 32'h0000_1000, "R2 addr lo");
    rd_chk(1, 32'h0000_1FFF, "R2 addr hi");
    rd_chk(3, 32'h0000_FFFF, "R2 data mask");
    rd_chk(5, 32'h0000_00FF, "R2 pc mask");
    rd_chk(7, 0, "R2 select 7");

    @(negedge clk);
    ser_wr = 1; ser_sel = 2; ser_wdata = 32'hA5A5_0000;
    sw_wr = 1; sw_sel = 2; sw_wdata = 32'hDEAD_BEEF;
    push(0, 0, "R3 both write");
    @(posedge clk); #2;
    @(negedge clk);
    ser_wr = 1; ser_sel = 4; ser_wdata = 32'h1000_0000;
    sw_wr = 1; sw_sel = 3; sw_wdata = 32'h0000_0001;
    push(0, 0, "R3 both write");
    @(posedge clk); #2;
    ser_wr = 0; sw_wr = 0;
    rd_chk(2, 32'hA5A5_0000, "R3 serial wins");
    rd_chk(3, 32'h0000_FFFF, "R3 supervisor dropped");

    step(1, 32'h1000, 32'hA5A5_0000, 32'h1000_0000, 0, 0, "R7 no enables");
    idle();

    wr(1, 6, 32'h001);
    rd_chk(6, 32'h001, "R2 ctrl readback");
    step(1, 32'h0FFF, 0, IDLE_PC, 0, 0, "R4 below low");
    step(0, 32'h1000, 0, IDLE_PC, 0, 0, "R4 invalid strobe");
    step(1, 32'h1000, 0, IDLE_PC, 1, 0, "R4 R8 low bound fire");
    step(1, 32'h1500, 0, IDLE_PC, 0, 0, "R11 no refire");
    wr(0, 6, 32'h001);
    step(1, 32'h1FFF, 0, IDLE_PC, 1, 0, "R4 high bound fire");
    wr(1, 6, 32'h001);
    step(1, 32'h2000, 0, IDLE_PC, 0, 0, "R4 above high");
    idle();

    wr(1, 6, 32'h202);
    step(0, 0, 32'hA5A5_0000, IDLE_PC, 0, 0, "R5 invalid strobe");
    step(1, 0, 32'hA4A5_0000, IDLE_PC, 0, 0, "R5 unmasked mismatch");
    step(1, 0, 32'hA5A5_1234, IDLE_PC, 0, 1, "R5 R10 masked match irq");
    idle();

    wr(0, 6, 32'h004);
    step(0, 0, 0, 32'h1000_01AB, 0, 0, "R6 pc mismatch");
    step(0, 0, 0, 32'h1000_00AB, 1, 0, "R6 pc match without valid");
    idle();

    wr(1, 6, 32'h003);
    step(1, 32'h1000, 32'h5A5A_0000, IDLE_PC, 0, 0, "R7 AND partial");
    step(1, 32'h1000, 32'hA5A5_0001, IDLE_PC, 1, 0, "R7 AND full");
    wr(1, 6, 32'h00B);
    step(1, 32'h3000, 32'hA5A5_0000, IDLE_PC, 1, 0, "R7 OR one");
    idle();

    wr(0, 6, 32'h341);
    step(0, 0, 0, 32'h1000_0042, 0, 0, "R9 level2 unarmed");
    step(1, 32'h1000, 0, 32'h1000_0042, 0, 0, "R9 arm cycle no fire");
    step(0, 0, 0, IDLE_PC, 0, 0, "R9 armed waiting");
    step(0, 0, 0, 32'h1000_0042, 0, 1, "R9 R10 level2 fire irq");
    step(0, 0, 0, 32'h1000_0042, 0, 0, "R11 spent");
    idle();

    wr(1, 6, 32'h341);
    step(1, 32'h1000, 0, IDLE_PC, 0, 0, "R9 arm");
    wr(1, 6, 32'h341);
    step(0, 0, 0, 32'h1000_0042, 0, 0, "R11 write clears armed");
    idle();

    wr(1, 6, 32'h004);
    step(0, 0, 0, 32'h1000_0011, 1, 0, "R11 fire before rewrite");
    wr(0, 6, 32'h004);
    step(0, 0, 0, 32'h1000_0011, 1, 0, "R11 rewrite rearms");
    idle();

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule